// File: doc/BRIEF.md
# LED Driver Serial Frame Sequencer

This block feeds a constant-current LED driver over a one-way serial link made of a clock line (`sck`) and a data line (`sin`). A `start` strobe begins a frame of sixteen 16-bit words. The block fetches each word over a request/valid handshake, then shifts it out most significant bit first in mode 0: `sck` idles low and the driver samples on the rising edge. While the words go out, the control line `trans` stays low.

After the last word the block issues a latch command on the same `sck` line. It raises `trans`, gives exactly three clock pulses with no data, and then drops `trans`. Both commands come from one state machine, so only one of them ever drives `sck`. The host gets a one-cycle `done` pulse when the frame is finished.

Independently of the serial link, the block generates `pwmclk`. This is a free-running square wave used as the driver's grayscale reference, with a period given as a count of system clock ticks. A newly written period takes effect only at the next counter reload.

Top module: `led_frame_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `sck`, `sin`, `trans`, `busy`, `done` and `word_req` are all low.
- R2: A frame sends 16 words in index order. Word k is requested with `word_idx` = k while `word_req` is high, and is taken in the cycle `word_valid` is high. Each word is shifted out MSB first, one bit per rising edge of `sck`, with `trans` low.
- R3: `sin` changes only while `sck` is low. It is stable on the cycle before every rising edge and for the whole high phase.
- R4: After word 15, `trans` rises while `sck` is low. `sck` then makes exactly three low-to-high pulses while `sin` is held low. `trans` falls after the final low phase, with `sck` low.
- R5: `done` is high for exactly one cycle: the cycle in which `trans` first reads low after the latch. `busy` is low from that cycle on.
- R6: A `start` pulse while `busy` is high has no effect. The frame in flight completes normally and no second frame follows.
- R7: Every high phase and every low phase of `sck` lasts at least `PH` system clock cycles (default 2, so the serial clock is at most clk/4).
- R8: `pwmclk` repeats with a period of P cycles and is high for the first floor(P/2) cycles of each period. P is 40 after reset.
- R9: A period written through `per_wr`/`per_val` is adopted only when the counter wraps. Every `pwmclk` high or low run is therefore the full half-period of either the old value or the new value, never a short run.
- R10: A reset asserted mid-frame aborts the frame and restarts the reference counter, so `pwmclk` is high in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| per_wr | input | 1 | Load a new reference period |
| per_val | input | PER_W | New reference period in clock ticks |
| word_req | output | 1 | Block is waiting for the next word |
| word_idx | output | $clog2(WORDS) | Index of the requested word |
| word_data | input | WORD_W | Word supplied by the host |
| word_valid | input | 1 | `word_data` is valid for the requested index |
| sck | output | 1 | Serial clock to the driver |
| sin | output | 1 | Serial data to the driver |
| trans | output | 1 | Latch control line |
| pwmclk | output | 1 | Grayscale reference clock |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench feeds random frames plus all-zero, all-one and alternating-bit frames. Words are answered after random handshake delays, which catches a design that shifts stale data or skips the wait and sends the wrong word. A monitor counts rising edges of `sck` while `trans` is high, so an off-by-one loop that gives two or four latch pulses is caught. The monitor also checks that `sin` never moves during a high phase and that no `sck` phase is shorter than the divider allows. For the reference clock, a period rewrite in the middle of a cycle exposes a design that reloads at once and emits a short pulse. A second `start` during a frame exposes a design that restarts or queues a frame.

// File: rtl/led_frame_seq.sv
module led_frame_seq #(
  parameter int WORDS     = 16,
  parameter int WORD_W    = 16,
  parameter int PH        = 2,
  parameter int LATCH_CYC = 3,
  parameter int PER_W     = 16,
  parameter int PER_DEF   = 40
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       per_wr,
  input  logic [PER_W-1:0]           per_val,
  output logic                       word_req,
  output logic [$clog2(WORDS)-1:0]   word_idx,
  input  logic [WORD_W-1:0]          word_data,
  input  logic                       word_valid,
  output logic                       sck,
  output logic                       sin,
  output logic                       trans,
  output logic                       pwmclk,
  output logic                       busy,
  output logic                       done
);
  localparam int WIW = $clog2(WORDS);
  localparam int BW  = $clog2(WORD_W);
  localparam int PHW = (PH > 1) ? $clog2(PH) : 1;
  localparam int HCW = $clog2(2*LATCH_CYC+1);
  localparam logic [PHW-1:0]   PH_LAST   = PHW'(PH-1);
  localparam logic [BW-1:0]    BIT_LAST  = BW'(WORD_W-1);
  localparam logic [WIW-1:0]   WORD_LAST = WIW'(WORDS-1);
  localparam logic [HCW-1:0]   HC_LAST   = HCW'(2*LATCH_CYC);
  localparam logic [PER_W-1:0] PER_MIN   = PER_W'(2);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_LATCH} st_t;

  st_t              st;
  logic [PHW-1:0]   ph;
  logic [BW-1:0]    bit_cnt;
  logic [WIW-1:0]   word_cnt;
  logic [WORD_W-1:0] sreg;
  logic [HCW-1:0]   hc;
  logic [PER_W-1:0] pcnt, per_cur, per_pend;

  wire ph_end = (ph == PH_LAST);

  assign word_req = (st == S_LOAD);
  assign word_idx = word_cnt;
  assign busy     = (st != S_IDLE);
  assign pwmclk   = (pcnt < (per_cur >> 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= '0; bit_cnt <= '0; word_cnt <= '0; sreg <= '0; hc <= '0;
      sck <= 1'b0; sin <= 1'b0; trans <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_SHIFT || st == S_LATCH) ph <= ph_end ? '0 : ph + 1'b1;
      else ph <= '0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_LOAD;
          word_cnt <= '0;
        end
        S_LOAD: if (word_valid) begin
          sreg <= word_data;
          sin <= word_data[WORD_W-1];
          bit_cnt <= '0;
          st <= S_SHIFT;
        end
        S_SHIFT: if (ph_end) begin
          if (!sck) sck <= 1'b1;
          else begin
            sck <= 1'b0;
            if (bit_cnt == BIT_LAST) begin
              if (word_cnt == WORD_LAST) begin
                st <= S_LATCH; trans <= 1'b1; sin <= 1'b0; hc <= '0;
              end else begin
                word_cnt <= word_cnt + 1'b1;
                st <= S_LOAD;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              sreg <= sreg << 1;
              sin <= sreg[WORD_W-2];
            end
          end
        end
        S_LATCH: if (ph_end) begin
          if (hc == HC_LAST) begin
            trans <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end else begin
            hc <= hc + 1'b1;
            sck <= ~sck;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0; per_cur <= PER_W'(PER_DEF); per_pend <= PER_W'(PER_DEF);
    end else begin
      if (per_wr) per_pend <= (per_val < PER_MIN) ? PER_MIN : per_val;
      if (pcnt == per_cur - 1'b1) begin
        pcnt <= '0;
        per_cur <= per_pend;
      end else pcnt <= pcnt + 1'b1;
    end
  end

  a_r3_sin_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(sin));
  a_r4_sin_low_latch: assert property (@(posedge clk) disable iff (rst)
    trans |-> !sin);
  a_r4_trans_edges_sck_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(trans) || $fell(trans)) |-> !sck);
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> (!trans && !busy));
  a_r9_period_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (per_cur != $past(per_cur)) |-> (pcnt == '0));
endmodule

// File: tb/led_frame_seq_tb.sv
`timescale 1ns/1ps
module led_frame_seq_tb;
  localparam int PH = 2;
  logic clk = 0, rst = 1, start = 0, per_wr = 0, word_valid = 0;
  logic [15:0] per_val = '0, word_data = '0;
  logic word_req, sck, sin, trans, pwmclk, busy, done;
  logic [3:0] word_idx;

  led_frame_seq u_dut (.clk(clk), .rst(rst), .start(start), .per_wr(per_wr), .per_val(per_val),
    .word_req(word_req), .word_idx(word_idx), .word_data(word_data), .word_valid(word_valid),
    .sck(sck), .sin(sin), .trans(trans), .pwmclk(pwmclk), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  logic [15:0] expw [16];
  int frames = 0;
  int last_hi = 0, last_lo = 0;
  bit pwm_chk = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int kind, input int idx);
    case (kind)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return (idx % 2) ? 16'h5555 : 16'hAAAA;
      default: return 16'($urandom);
    endcase
  endfunction

  // word supplier with random handshake delay
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (rst) word_valid = 0;
      else if (word_valid) word_valid = 0;
      else if (word_req) begin
        if (dly == 0) begin
          word_data = expw[word_idx];
          word_valid = 1;
          dly = $urandom % 4;
        end else dly--;
      end
    end
  end

  // serial and reference clock monitor
  initial begin
    logic p_sck = 0, p_sin = 0, p_trans = 0, p_done = 0, p_pwm = 0;
    logic [15:0] rx = 0;
    int wcnt = 0, bcnt = 0, ledges = 0, run = 0, prun = 0;
    bit pseen = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        wcnt = 0; bcnt = 0; ledges = 0; run = 0; pseen = 0; prun = 0;
      end else begin
        if (sck && !p_sck) begin
          chk(sin == p_sin, "R3 sin stable before rise", sin, p_sin);
          if (trans) ledges++;
          else begin
            rx = {rx[14:0], sin};
            bcnt++;
            if (bcnt == 16) begin
              chk(rx == expw[wcnt], "R2 word content", rx, expw[wcnt]);
              wcnt++; bcnt = 0;
            end
          end
        end
        if (sck && p_sck) chk(sin == p_sin, "R3 sin moved while sck high", sin, p_sin);
        if (sck != p_sck) begin
          chk(run >= PH, "R7 sck phase length", run, PH);
          run = 1;
        end else run++;
        if (trans && !p_trans) chk(!sck, "R4 sck low at trans rise", sck, 0);
        if (trans) chk(!sin, "R4 sin low during latch", sin, 0);
        if (!trans && p_trans) begin
          chk(ledges == 3, "R4 latch pulse count", ledges, 3);
          chk(wcnt == 16 && bcnt == 0, "R2 words per frame", wcnt, 16);
          chk(done && !sck, "R5 done in trans fall cycle", done, 1);
          frames++; ledges = 0; wcnt = 0;
        end
        if (done && p_done) chk(0, "R5 done longer than one cycle", 2, 1);
        if (pwmclk != p_pwm) begin
          if (pseen) begin
            if (p_pwm) last_hi = prun; else last_lo = prun;
            if (pwm_chk) chk(prun == 20 || prun == 32, "R9 no short pwm run", prun, 32);
          end
          pseen = 1; prun = 1;
        end else prun++;
      end
      p_sck = sck; p_sin = sin; p_trans = trans; p_done = done; p_pwm = pwmclk;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic run_frame(input int kind);
    int f0;
    for (int i = 0; i < 16; i++) expw[i] = pattern(kind, i);
    f0 = frames;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk(!busy, "R5 busy low with done", busy, 0);
    @(negedge clk);
    chk(frames == f0 + 1, "R2 one frame completed", frames - f0, 1);
    chk(!done, "R5 done single cycle", done, 0);
  endtask

  initial begin
    int f0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) expw[i] = 0;
    repeat (3) @(negedge clk);
    chk({sck, sin, trans, busy, done, word_req} == 6'b0, "R1 outputs in reset",
        {sck, sin, trans, busy, done, word_req}, 0);
    rst = 0;
    @(negedge clk);
    chk({sck, sin, trans, busy, done, word_req} == 6'b0, "R1 outputs after reset",
        {sck, sin, trans, busy, done, word_req}, 0);
    repeat (200) @(negedge clk);
    chk(last_hi == 20, "R8 default high run", last_hi, 20);
    chk(last_lo == 20, "R8 default low run", last_lo, 20);

    for (int k = 0; k < 3; k++) run_frame(k);
    for (int k = 0; k < 3; k++) run_frame(3);

    // R6: start while busy
    for (int i = 0; i < 16; i++) expw[i] = pattern(3, i);
    f0 = frames;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (300) @(negedge clk);
    chk(busy, "R6 busy mid-frame", busy, 1);
    start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(!busy, "R6 no second frame", busy, 0);
    chk(frames == f0 + 1, "R6 frame count", frames - f0, 1);

    // R9: period rewrite mid-cycle
    pwm_chk = 1;
    while (!pwmclk) @(negedge clk);
    repeat (7) @(negedge clk);
    per_val = 16'd64; per_wr = 1;
    @(negedge clk); per_wr = 0;
    repeat (300) @(negedge clk);
    chk(last_hi == 32, "R9 new high run", last_hi, 32);
    chk(last_lo == 32, "R9 new low run", last_lo, 32);
    pwm_chk = 0;

    // R10: reset mid-frame
    for (int i = 0; i < 16; i++) expw[i] = pattern(3, i);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (200) @(negedge clk);
    while (pwmclk) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk({sck, sin, trans, busy} == 4'b0, "R10 frame aborted", {sck, sin, trans, busy}, 0);
    rst = 0;
    @(negedge clk);
    chk(pwmclk, "R10 reference restarted high", pwmclk, 1);
    repeat (100) @(negedge clk);
    chk(last_hi == 20 && last_lo == 20, "R10 default period restored", last_hi, 20);
    run_frame(3);
    summary();
  end
endmodule